// File: doc/BRIEF.md
# Dual-Core Shared Memory Arbiter

Two processor cores share a single-ported data RAM. Each core drives a request with write enable, word address and write data, and holds them steady while its stall output is high. The arbiter decides which core may use the RAM and inserts a synchronization cycle in front of every access, so that no access finishes in less than two cycles. It returns read data on the cycle the stall drops. A write is committed on that same cycle.

Ownership is sticky. The core that wins keeps the RAM for as long as its requests keep coming, and gives it up only after a fixed run of cycles in which it makes no request. A core that issues back-to-back accesses, or accesses separated by a single idle cycle, can therefore keep the other core waiting for an unlimited time. When both cores ask for the RAM while no core owns it, core 0 wins. The RAM answers only inside a word-aligned address window. Requests that fall outside the window are ignored.

Top module: `shmem_arbiter`

## Requirements
- R1: After reset neither core owns the RAM, so a first request from core 1 alone is served without waiting for core 0.
- R2: An in-window access with the RAM free takes exactly two cycles. In the first cycle stall is high, and in the second cycle stall is low and the access completes.
- R3: If both cores present an in-window request while no core owns the RAM, core 0 is served and core 1 stays stalled.
- R4: In any cycle at most one core completes an in-window access.
- R5: Once a core owns the RAM, it keeps ownership until it has gone 2 consecutive cycles (IDLE_CYC) with no in-window request. Until then any request from the other core stays stalled.
- R6: A waiting core whose owner goes quiet after completing an access in cycle G first gets a fresh synchronization cycle, and then completes in cycle G+4.
- R7: A burst from the owning core with no gaps completes one access every 2 cycles, so N accesses finish 2N-1 cycles after the first is issued.
- R8: A write takes effect exactly once, in the cycle its stall is low. A read returns the last value committed to that word. Every request issued is completed exactly once.
- R9: The window covers word addresses BASE to BASE+DEPTH-1 (default 0x020000, 64 words). A request outside it sees stall low at once, and it changes neither the RAM nor ownership.
- R10: An owner that leaves only one idle cycle between accesses keeps the RAM for its whole burst. A waiting core completes exactly 4 cycles after the owner's last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Core 0 access request |
| c0_we | input | 1 | Core 0 write enable |
| c0_addr | input | ADDR_W | Core 0 word address |
| c0_wdata | input | DATA_W | Core 0 write data |
| c0_stall | output | 1 | Core 0 must hold its request |
| c0_rdata | output | DATA_W | Core 0 read data, valid when a read's stall is low |
| c1_req | input | 1 | Core 1 access request |
| c1_we | input | 1 | Core 1 write enable |
| c1_addr | input | ADDR_W | Core 1 word address |
| c1_wdata | input | DATA_W | Core 1 write data |
| c1_stall | output | 1 | Core 1 must hold its request |
| c1_rdata | output | DATA_W | Core 1 read data, valid when a read's stall is low |

## Verification
Two things can land in the same cycle. One is the release of ownership after the owner's idle run. The other is a fresh request, either from the old owner or from a core that has been waiting. The bench provokes this by starting both cores together, by making core 1 wait behind bursts from core 0 that have gaps of zero and one cycle, and by running random traffic with gaps of zero to three cycles. A behavioural model predicts both stall outputs and every read value on each clock. At the end, the bench checks that every issued access completed exactly once.

// File: rtl/shmem_arbiter.sv
module shmem_arbiter #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int DEPTH = 64,
  parameter int IDLE_CYC = 2,
  parameter logic [ADDR_W-1:0] BASE = 'h020000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c0_req,
  input  logic              c0_we,
  input  logic [ADDR_W-1:0] c0_addr,
  input  logic [DATA_W-1:0] c0_wdata,
  output logic              c0_stall,
  output logic [DATA_W-1:0] c0_rdata,
  input  logic              c1_req,
  input  logic              c1_we,
  input  logic [ADDR_W-1:0] c1_addr,
  input  logic [DATA_W-1:0] c1_wdata,
  output logic              c1_stall,
  output logic [DATA_W-1:0] c1_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int IC_W = $clog2(IDLE_CYC + 1);
  localparam logic [ADDR_W-IDX_W-1:0] PAGE = BASE[ADDR_W-1:IDX_W];

  logic              hit0, hit1, eff0, eff1;
  logic [1:0]        own_q, sel;
  logic              ph_q, act, grant0, grant1, we_sel;
  logic [IC_W-1:0]   idle_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wd_sel, rd_q;
  logic [DATA_W-1:0] mem [DEPTH];

  assign hit0 = c0_addr[ADDR_W-1:IDX_W] == PAGE;
  assign hit1 = c1_addr[ADDR_W-1:IDX_W] == PAGE;
  assign eff0 = c0_req & hit0;
  assign eff1 = c1_req & hit1;

  // owner first; with no owner, core 0 beats core 1
  assign sel = (|own_q) ? own_q : (eff0 ? 2'b01 : (eff1 ? 2'b10 : 2'b00));
  assign act = (sel[0] & eff0) | (sel[1] & eff1);
  assign grant0 = sel[0] & eff0 & ph_q;
  assign grant1 = sel[1] & eff1 & ph_q;

  assign c0_stall = eff0 & ~grant0;
  assign c1_stall = eff1 & ~grant1;

  assign idx    = sel[1] ? c1_addr[IDX_W-1:0] : c0_addr[IDX_W-1:0];
  assign we_sel = sel[1] ? c1_we : c0_we;
  assign wd_sel = sel[1] ? c1_wdata : c0_wdata;

  assign c0_rdata = rd_q;
  assign c1_rdata = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= 2'b00;
      ph_q   <= 1'b0;
      idle_q <= '0;
    end else if (act) begin
      own_q  <= sel;
      ph_q   <= ~ph_q;
      idle_q <= '0;
    end else begin
      ph_q <= 1'b0;
      if (|own_q) begin
        if (idle_q == IC_W'(IDLE_CYC - 1)) begin
          own_q  <= 2'b00;
          idle_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (act & ~ph_q) rd_q <= mem[idx];
    if (act & ph_q & we_sel) mem[idx] <= wd_sel;
  end
endmodule

module shmem_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       c0_req,
  input logic       c1_req,
  input logic       hit0,
  input logic       hit1,
  input logic       c0_stall,
  input logic       c1_stall,
  input logic [1:0] own_q
);
  logic g0, g1;
  assign g0 = c0_req & hit0 & ~c0_stall;
  assign g1 = c1_req & hit1 & ~c1_stall;

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n) !(g0 && g1));
  assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(own_q));
  assert_sync_first0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    g0 |-> $past(c0_req && hit0 && c0_stall));
  assert_sync_first1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    g1 |-> $past(c1_req && hit1 && c1_stall));
  assert_tie_core0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == 2'b00 && c0_req && hit0 && c1_req && hit1) |-> c1_stall);
  assert_outside0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && !hit0) |-> !c0_stall);
  assert_outside1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_req && !hit1) |-> !c1_stall);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != 2'b00) |=> (own_q == $past(own_q) || own_q == 2'b00));
  assert_quiet_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(own_q[0]) && own_q == 2'b00) |-> !$past(c0_req && hit0));
  assert_waiter_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == 2'b01 && c1_req && hit1) |-> c1_stall);
endmodule

bind shmem_arbiter shmem_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .c0_req(c0_req), .c1_req(c1_req),
  .hit0(hit0), .hit1(hit1), .c0_stall(c0_stall), .c1_stall(c1_stall),
  .own_q(own_q)
);

// File: tb/shmem_arbiter_test.sv
`timescale 1ns/1ps
module shmem_arbiter_test;
  localparam int DEPTH = 64;
  localparam int BASE = 'h020000;
  localparam int LIMIT = 100000;

  typedef struct {int a; bit we; int d; int g;} txn_t;

  logic clk = 0, rst_n = 0;
  logic c0_req = 0, c0_we = 0, c1_req = 0, c1_we = 0;
  logic [23:0] c0_addr = '0, c1_addr = '0;
  logic [15:0] c0_wdata = '0, c1_wdata = '0;
  logic c0_stall, c1_stall;
  logic [15:0] c0_rdata, c1_rdata;

  shmem_arbiter uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit wd_hit = 0;
  int m_own = -1, m_idle = 0, m_ph = 0;
  logic [15:0] m_mem [DEPTH];
  txn_t q [2][$];
  txn_t cur [2];
  bit busy [2];
  int wcnt [2], issue_cyc [2], grant_cyc [2], ngrant [2], npush [2];
  logic [15:0] last_rd [2];

  function automatic bit inwin(int a);
    return (a / DEPTH) == (BASE / DEPTH);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(int c, int a, bit we, int d, int g);
    txn_t t;
    t.a = a; t.we = we; t.d = d; t.g = g;
    q[c].push_back(t);
    npush[c]++;
  endtask

  task automatic step();
    bit e [2];
    bit st [2];
    bit gr [2];
    bit act_st [2];
    logic [15:0] rd [2];
    int sel;
    bit act;
    string tag;
    @(negedge clk);
    cyc++;
    for (int c = 0; c < 2; c++) begin
      if (!busy[c] && q[c].size() > 0) begin
        if (wcnt[c] < q[c][0].g) wcnt[c]++;
        else begin
          cur[c] = q[c].pop_front();
          busy[c] = 1;
          wcnt[c] = 0;
          issue_cyc[c] = cyc;
        end
      end
    end
    c0_req = busy[0]; c0_we = cur[0].we; c0_addr = cur[0].a[23:0]; c0_wdata = cur[0].d[15:0];
    c1_req = busy[1]; c1_we = cur[1].we; c1_addr = cur[1].a[23:0]; c1_wdata = cur[1].d[15:0];
    #1;
    act_st[0] = c0_stall; act_st[1] = c1_stall;
    rd[0] = c0_rdata; rd[1] = c1_rdata;
    for (int c = 0; c < 2; c++) e[c] = busy[c] && inwin(cur[c].a);
    sel = (m_own >= 0) ? m_own : (e[0] ? 0 : (e[1] ? 1 : -1));
    act = (sel >= 0) && e[sel];
    for (int c = 0; c < 2; c++) begin
      st[c] = e[c] && !(act && sel == c && m_ph == 1);
      if (busy[c] && !inwin(cur[c].a)) tag = "R9";
      else if (m_own >= 0 && m_own != c) tag = "R5";
      else if (m_own < 0 && e[0] && e[1] && c == 1) tag = "R3";
      else tag = "R2";
      check(act_st[c] === st[c], tag, $sformatf("stall core%0d cycle %0d", c, cyc), int'(act_st[c]), int'(st[c]));
      gr[c] = busy[c] && !st[c];
    end
    if (e[0] && e[1])
      check(!(!act_st[0] && !act_st[1]), "R4", "both cores completed", 1, 0);
    for (int c = 0; c < 2; c++) begin
      if (gr[c] && e[c] && !cur[c].we) begin
        last_rd[c] = rd[c];
        check(rd[c] === m_mem[cur[c].a % DEPTH], "R8", $sformatf("read core%0d word %0d", c, cur[c].a % DEPTH),
              int'(rd[c]), int'(m_mem[cur[c].a % DEPTH]));
      end
      if (gr[c] && e[c] && cur[c].we) m_mem[cur[c].a % DEPTH] = cur[c].d[15:0];
    end
    if (act) begin
      m_ph = 1 - m_ph; m_own = sel; m_idle = 0;
    end else begin
      m_ph = 0;
      if (m_own >= 0) begin
        m_idle++;
        if (m_idle == 2) begin m_own = -1; m_idle = 0; end
      end
    end
    for (int c = 0; c < 2; c++)
      if (gr[c]) begin busy[c] = 0; grant_cyc[c] = cyc; ngrant[c]++; end
    if (cyc > LIMIT) wd_hit = 1;
  endtask

  task automatic drain(int extra);
    while ((q[0].size() > 0 || q[1].size() > 0 || busy[0] || busy[1]) && !wd_hit) step();
    for (int i = 0; i < extra; i++) step();
  endtask

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state, then core 1 alone is served at once
    @(negedge clk); #1;
    check(c0_stall === 1'b0 && c1_stall === 1'b0, "R1", "stalls idle after reset", int'({c0_stall, c1_stall}), 0);
    push(1, BASE + 9, 1, 'h1234, 0);
    drain(3);
    check(grant_cyc[1] - issue_cyc[1] == 1, "R1", "first core1 access latency", grant_cyc[1] - issue_cyc[1], 1);

    // R7: gapless burst filling the window
    t0 = cyc + 1;
    for (int i = 0; i < DEPTH; i++) push(0, BASE + i, 1, 'hA500 + i, 0);
    drain(4);
    check(grant_cyc[0] == t0 + 2 * DEPTH - 1, "R7", "burst end cycle", grant_cyc[0], t0 + 2 * DEPTH - 1);

    // R2: isolated read
    push(0, BASE + 5, 0, 0, 0);
    drain(4);
    check(grant_cyc[0] - issue_cyc[0] == 1, "R2", "isolated read latency", grant_cyc[0] - issue_cyc[0], 1);
    check(last_rd[0] === 16'hA505, "R8", "read after burst write", int'(last_rd[0]), 'hA505);

    // R3 and R6: simultaneous start
    push(0, BASE + 1, 0, 0, 0);
    push(1, BASE + 2, 0, 0, 0);
    drain(4);
    check(grant_cyc[0] < grant_cyc[1], "R3", "core0 first on tie", grant_cyc[0], grant_cyc[1]);
    check(grant_cyc[1] == grant_cyc[0] + 4, "R6", "handover cycle", grant_cyc[1], grant_cyc[0] + 4);

    // R10: owner with one idle cycle between accesses holds the RAM
    for (int i = 0; i < 16; i++) push(0, BASE + i, 0, 0, (i == 0) ? 0 : 1);
    push(1, BASE + 20, 1, 'h5A5A, 1);
    drain(4);
    check(grant_cyc[1] == grant_cyc[0] + 4, "R10", "waiter after spaced burst", grant_cyc[1], grant_cyc[0] + 4);

    // R9: write just past the window aliases word 0 if decode is wrong
    push(1, BASE + DEPTH, 1, 'hBEEF, 0);
    drain(0);
    check(grant_cyc[1] == issue_cyc[1], "R9", "out-of-window completes at once", grant_cyc[1] - issue_cyc[1], 0);
    push(1, BASE, 0, 0, 0);
    drain(4);
    check(last_rd[1] === 16'hA500, "R9", "word 0 untouched", int'(last_rd[1]), 'hA500);

    // random contending traffic
    for (int i = 0; i < 300; i++) begin
      for (int c = 0; c < 2; c++) begin
        int a;
        a = ($urandom % 10 == 0) ? (BASE + DEPTH + int'($urandom % 200)) : (BASE + int'($urandom % DEPTH));
        push(c, a, 1'($urandom), int'($urandom % 65536), int'($urandom % 4));
      end
    end
    drain(4);
    for (int c = 0; c < 2; c++)
      check(ngrant[c] == npush[c], "R8", $sformatf("core%0d completions", c), ngrant[c], npush[c]);

    if (wd_hit) begin
      checks++; fails++;
      $display("FAIL R8 watchdog expired: actual cycles %0d expected < %0d", cyc, LIMIT);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule